// File: doc/BRIEF.md
# Link-State Transaction Gate

This block sits between a host-side request source and the transaction layer of a serial link. Each outbound request carries a class code and a host tag. The block forwards the request to the link, drops it, errors it, or answers it locally. The choice depends on whether the link is up and on whether a reset clean-up is running. The block detects hot resets and unexpected link drops from their edges. It keeps a sticky link-down flag, pulses a clear toward the non-sticky configuration bits, and retires every outstanding non-posted request with an error before it reports that it is idle again.

A separate gate handles inbound configuration requests. It answers them with a retry until software marks the device ready, but only when the boot-mode input asks for that hold. The block runs in root-complex mode or endpoint mode. Only a root complex can drive a hot reset onto the link.

Outbound requests use a valid/ready handshake toward the link. A request moves on a cycle in which both valid and ready are high. The host must keep `ob_valid`, `ob_class` and `ob_tag` stable until `ob_ready` is seen. The block pulls `ob_ready` low in three cases: when the link side stalls (`tl_ready` low), when a non-posted request finds no free tracking slot, and while a reset clean-up is in progress. The response port has no back-pressure. Each response is a one-cycle pulse, and the consumer must take it.

Top module: `link_gate_ctrl`

## Requirements
- R1: While `link_up` is 0, a posted request (class 2'b00) is accepted at once (`ob_ready`=1). It never appears on `tl_valid` and produces no response.
- R2: While `link_up` is 0, a non-posted memory request (class 2'b01 or 2'b11) is accepted. One cycle later `rsp_valid` pulses with `rsp_status`=1 (error), `rsp_data`=0 and the request's tag.
- R3: While `link_up` is 0, a configuration read (class 2'b10) is accepted. One cycle later a response pulses with `rsp_status`=0 and `rsp_data` all ones.
- R4: While `link_up` is 1 and no clean-up is running, requests pass to `tl_valid` with class and tag unchanged, and `ob_ready` follows `tl_ready`. A non-posted request takes the lowest-numbered free tracking slot, which is shown on `tl_slot`.
- R5: `ldd` sets on a 1-to-0 transition of `link_up` and stays set until a `ldd_clr` pulse clears it. If a set and a clear land in the same cycle, the set wins.
- R6: A hot-reset event or a link-drop event refuses outbound requests in the event cycle. From the next cycle `cleaning` is 1, and each cycle it errors one pending slot, lowest number first (response status 1, data 0, the stored tag, one cycle later). `cleaning` falls once no slot is pending.
- R7: `nsticky_clr` pulses for exactly one cycle, one cycle after a hot-reset event in either mode, or after a link-drop event in endpoint mode only (`mode_rc`=0).
- R8: `hot_reset_out` equals `sbr_ctl` when `mode_rc`=1 and is 0 when `mode_rc`=0. Its rising edge counts as a hot-reset event. A rising `hot_reset_in` is a hot-reset event in both modes.
- R9: While `boot_hold`=1 and `cfg_ready`=0, each inbound configuration request is consumed (`ib_ready`=1) with `ib_retry`=1 and is not forwarded.
- R10: `cfg_ready` is set by `cfg_ready_set` and cleared only by `rst_n`. After it is set, or at any time when `boot_hold`=0, inbound requests are forwarded with `ib_ready` following `ib_fwd_ready`.
- R11: `cpl_valid` frees the slot named by `cpl_slot`, and the next non-posted request may reuse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Fundamental reset, active low |
| mode_rc | input | 1 | 1 = root complex, 0 = endpoint |
| boot_hold | input | 1 | 1 = retry inbound configuration until ready |
| link_up | input | 1 | Link status from the link layer |
| hot_reset_in | input | 1 | Hot reset detected on the link |
| sbr_ctl | input | 1 | Secondary-bus-reset control bit |
| ldd_clr | input | 1 | Write-one-to-clear pulse for `ldd` |
| cfg_ready_set | input | 1 | Software sets configuration-ready |
| ob_valid | input | 1 | Outbound request valid |
| ob_ready | output | 1 | Outbound request accepted |
| ob_class | input | 2 | 00 posted, 01/11 non-posted memory, 10 configuration read |
| ob_tag | input | TAG_W | Host tag |
| tl_valid | output | 1 | Request to link valid |
| tl_ready | input | 1 | Link layer ready |
| tl_class | output | 2 | Forwarded class |
| tl_tag | output | TAG_W | Forwarded tag |
| tl_slot | output | SLOT_W | Tracking slot of a forwarded non-posted request |
| cpl_valid | input | 1 | Completion returned for a slot |
| cpl_slot | input | SLOT_W | Slot being completed |
| rsp_valid | output | 1 | Local response pulse |
| rsp_status | output | 1 | 0 OK, 1 error |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_data | output | DATA_W | Response data |
| ib_valid | input | 1 | Inbound configuration request valid |
| ib_ready | output | 1 | Inbound request consumed |
| ib_retry | output | 1 | Inbound request answered with retry |
| ib_fwd_valid | output | 1 | Inbound request forwarded |
| ib_fwd_ready | input | 1 | Downstream ready for inbound request |
| hot_reset_out | output | 1 | Hot reset driven onto the link |
| ldd | output | 1 | Sticky link-down-detected flag |
| nsticky_clr | output | 1 | Clear pulse for non-sticky configuration bits |
| cleaning | output | 1 | Clean-up in progress |
| cfg_ready | output | 1 | Configuration-ready flag |

## Verification
Each of the three request classes is sent with the link down and again with the link up. A wrong treatment therefore shows as a missing response, a response with the wrong status or data, or a request that leaks onto the link. Slot allocation is checked by filling slots, completing one and sending again, so a reused lowest slot can be told apart from a fresh one. The link is then dropped with two slots pending to confirm the order and tags of the error responses. Hot resets are raised from both sources in both modes, and link drops are raised in both modes, to separate which events pulse the clear. The inbound gate is tried before and after the ready flag is set, across a hot reset, and after a fundamental reset with boot hold off.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
  typedef enum logic [1:0] {
    CLS_POSTED = 2'b00,
    CLS_NP_MEM = 2'b01,
    CLS_CFG_RD = 2'b10,
    CLS_NP_ALT = 2'b11
  } req_cls_e;

  localparam logic ST_OK  = 1'b0;
  localparam logic ST_ERR = 1'b1;
endpackage

// File: rtl/lgc_link_events.sv
module lgc_link_events (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_rc,
  input  logic link_up,
  input  logic hot_reset_in,
  input  logic sbr_ctl,
  input  logic ldd_clr,
  output logic hot_reset_out,
  output logic reset_evt,
  output logic ldd,
  output logic nsticky_clr
);
  logic link_q, hr_q, hr_src, ld_evt, hr_evt;

  assign hot_reset_out = mode_rc & sbr_ctl;
  assign hr_src        = hot_reset_in | hot_reset_out;
  assign ld_evt        = link_q & ~link_up;
  assign hr_evt        = hr_src & ~hr_q;
  assign reset_evt     = ld_evt | hr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q      <= 1'b0;
      hr_q        <= 1'b0;
      ldd         <= 1'b0;
      nsticky_clr <= 1'b0;
    end else begin
      link_q      <= link_up;
      hr_q        <= hr_src;
      nsticky_clr <= hr_evt | (ld_evt & ~mode_rc);
      if (ld_evt)       ldd <= 1'b1;
      else if (ldd_clr) ldd <= 1'b0;
    end
  end

  AST_LDD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ld_evt |=> ldd); // R5
  AST_CLR_EP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_evt && mode_rc && !hr_evt) |=> !nsticky_clr); // R7
endmodule

// File: rtl/lgc_slot_table.sv
module lgc_slot_table #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              cpl_valid,
  input  logic [SLOT_W-1:0] cpl_slot,
  input  logic              drop_low,
  output logic              free_avail,
  output logic [SLOT_W-1:0] free_slot,
  output logic              any_pend,
  output logic              single_pend,
  output logic [TAG_W-1:0]  low_tag
);
  logic [SLOTS-1:0] pend;
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [SLOT_W-1:0] low_slot;

  always_comb begin
    free_avail = 1'b0;
    free_slot  = '0;
    any_pend   = 1'b0;
    low_slot   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!pend[i]) begin
        free_avail = 1'b1;
        free_slot  = SLOT_W'(i);
      end else begin
        any_pend = 1'b1;
        low_slot = SLOT_W'(i);
      end
    end
  end

  assign single_pend = ($countones(pend) == 1);
  assign low_tag     = tag_q[low_slot];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g]  <= 1'b0;
        tag_q[g] <= '0;
      end else if (alloc && free_slot == SLOT_W'(g)) begin
        pend[g]  <= 1'b1;
        tag_q[g] <= alloc_tag;
      end else if ((drop_low && low_slot == SLOT_W'(g)) ||
                   (cpl_valid && cpl_slot == SLOT_W'(g))) begin
        pend[g]  <= 1'b0;
      end
    end
  end

  AST_ALLOC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> any_pend); // R4
endmodule

// File: rtl/lgc_cfg_inbound.sv
module lgc_cfg_inbound (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_hold,
  input  logic cfg_ready_set,
  input  logic ib_valid,
  input  logic ib_fwd_ready,
  output logic ib_ready,
  output logic ib_retry,
  output logic ib_fwd_valid,
  output logic cfg_ready
);
  logic hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cfg_ready <= 1'b0;
    else if (cfg_ready_set) cfg_ready <= 1'b1;
  end

  assign hold         = boot_hold & ~cfg_ready;
  assign ib_retry     = ib_valid & hold;
  assign ib_fwd_valid = ib_valid & ~hold;
  assign ib_ready     = hold | ib_fwd_ready;

  AST_RETRY_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    ib_retry |-> boot_hold); // R9
  AST_RDY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready); // R10
endmodule

// File: rtl/link_gate_ctrl.sv
module link_gate_ctrl
  import lgc_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rc,
  input  logic              boot_hold,
  input  logic              link_up,
  input  logic              hot_reset_in,
  input  logic              sbr_ctl,
  input  logic              ldd_clr,
  input  logic              cfg_ready_set,
  input  logic              ob_valid,
  output logic              ob_ready,
  input  logic [1:0]        ob_class,
  input  logic [TAG_W-1:0]  ob_tag,
  output logic              tl_valid,
  input  logic              tl_ready,
  output logic [1:0]        tl_class,
  output logic [TAG_W-1:0]  tl_tag,
  output logic [SLOT_W-1:0] tl_slot,
  input  logic              cpl_valid,
  input  logic [SLOT_W-1:0] cpl_slot,
  output logic              rsp_valid,
  output logic              rsp_status,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              ib_valid,
  output logic              ib_ready,
  output logic              ib_retry,
  output logic              ib_fwd_valid,
  input  logic              ib_fwd_ready,
  output logic              hot_reset_out,
  output logic              ldd,
  output logic              nsticky_clr,
  output logic              cleaning,
  output logic              cfg_ready
);
  logic reset_evt, free_avail, any_pend, single_pend;
  logic [SLOT_W-1:0] free_slot;
  logic [TAG_W-1:0]  low_tag;
  logic is_np, is_cfg, link_ok, down_ok, slot_ok, alloc, drop_low, local_rsp;

  lgc_link_events i_events (
    .clk, .rst_n, .mode_rc, .link_up, .hot_reset_in, .sbr_ctl, .ldd_clr,
    .hot_reset_out, .reset_evt, .ldd, .nsticky_clr
  );

  lgc_slot_table #(.SLOTS(SLOTS), .TAG_W(TAG_W)) i_slots (
    .clk, .rst_n, .alloc, .alloc_tag(ob_tag), .cpl_valid, .cpl_slot,
    .drop_low, .free_avail, .free_slot, .any_pend, .single_pend, .low_tag
  );

  lgc_cfg_inbound i_inbound (
    .clk, .rst_n, .boot_hold, .cfg_ready_set, .ib_valid, .ib_fwd_ready,
    .ib_ready, .ib_retry, .ib_fwd_valid, .cfg_ready
  );

  assign is_np   = (ob_class != CLS_POSTED);
  assign is_cfg  = (ob_class == CLS_CFG_RD);
  assign link_ok = link_up & ~cleaning & ~reset_evt;
  assign down_ok = ~link_up & ~cleaning & ~reset_evt;
  assign slot_ok = ~is_np | free_avail;

  assign tl_valid = ob_valid & link_ok & slot_ok;
  assign tl_class = ob_class;
  assign tl_tag   = ob_tag;
  assign tl_slot  = free_slot;
  assign ob_ready = link_ok ? (tl_ready & slot_ok) : down_ok;

  assign alloc     = tl_valid & tl_ready & is_np;
  assign drop_low  = cleaning & any_pend;
  assign local_rsp = ob_valid & down_ok & is_np;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cleaning   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_tag    <= '0;
      rsp_data   <= '0;
    end else begin
      if (reset_evt)
        cleaning <= 1'b1;
      else if (cleaning && (!any_pend || single_pend))
        cleaning <= 1'b0;

      rsp_valid <= drop_low | local_rsp;
      if (drop_low) begin
        rsp_status <= ST_ERR;
        rsp_tag    <= low_tag;
        rsp_data   <= '0;
      end else if (local_rsp) begin
        rsp_status <= is_cfg ? ST_OK : ST_ERR;
        rsp_tag    <= ob_tag;
        rsp_data   <= is_cfg ? '1 : '0;
      end
    end
  end

  AST_CFG_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_OK) |-> (rsp_data == '1)); // R3
  AST_CLEAN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(cleaning)) |-> (rsp_status == ST_ERR)); // R6
endmodule

// File: tb/test_link_gate_ctrl.sv
module test_link_gate_ctrl;
  localparam int TAG_W = 4;
  localparam int SLOT_W = 2;

  logic clk = 1'b0;
  logic rst_n, mode_rc, boot_hold, link_up, hot_reset_in, sbr_ctl, ldd_clr, cfg_ready_set;
  logic ob_valid, ob_ready, tl_valid, tl_ready, cpl_valid;
  logic [1:0] ob_class, tl_class;
  logic [TAG_W-1:0] ob_tag, tl_tag, rsp_tag;
  logic [SLOT_W-1:0] tl_slot, cpl_slot;
  logic rsp_valid, rsp_status;
  logic [31:0] rsp_data;
  logic ib_valid, ib_ready, ib_retry, ib_fwd_valid, ib_fwd_ready;
  logic hot_reset_out, ldd, nsticky_clr, cleaning, cfg_ready;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  link_gate_ctrl i_link_gate_ctrl (
    .clk, .rst_n, .mode_rc, .boot_hold, .link_up, .hot_reset_in, .sbr_ctl,
    .ldd_clr, .cfg_ready_set, .ob_valid, .ob_ready, .ob_class, .ob_tag,
    .tl_valid, .tl_ready, .tl_class, .tl_tag, .tl_slot, .cpl_valid, .cpl_slot,
    .rsp_valid, .rsp_status, .rsp_tag, .rsp_data, .ib_valid, .ib_ready,
    .ib_retry, .ib_fwd_valid, .ib_fwd_ready, .hot_reset_out, .ldd,
    .nsticky_clr, .cleaning, .cfg_ready
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [1:0] cls, input logic [TAG_W-1:0] tag);
    ob_valid = 1'b1; ob_class = cls; ob_tag = tag;
    #1;
  endtask

  task automatic t_reset();
    chk("R5 ldd after reset", ldd, 0);
    chk("R6 cleaning after reset", cleaning, 0);
    chk("R7 clr after reset", nsticky_clr, 0);
    chk("R10 cfg_ready after reset", cfg_ready, 0);
    chk("R8 hot_reset_out after reset", hot_reset_out, 0);
  endtask

  task automatic t_down_classes();
    send(2'b00, 4'd1);
    chk("R1 posted ready", ob_ready, 1);
    chk("R1 posted not forwarded", tl_valid, 0);
    tick(); ob_valid = 1'b0;
    chk("R1 posted no response", rsp_valid, 0);
    send(2'b01, 4'd5);
    tick(); ob_valid = 1'b0;
    chk("R2 np rsp valid", rsp_valid, 1);
    chk("R2 np status", rsp_status, 1);
    chk("R2 np tag", rsp_tag, 5);
    chk("R2 np data", rsp_data, 0);
    send(2'b10, 4'd6);
    tick(); ob_valid = 1'b0;
    chk("R3 cfg rsp valid", rsp_valid, 1);
    chk("R3 cfg status", rsp_status, 0);
    chk("R3 cfg data", rsp_data, 32'hFFFF_FFFF);
    tick();
  endtask

  task automatic t_forward();
    link_up = 1'b1; tick();
    tl_ready = 1'b0; send(2'b00, 4'd7);
    chk("R4 forwarded valid", tl_valid, 1);
    chk("R4 backpressure", ob_ready, 0);
    tl_ready = 1'b1; #1;
    chk("R4 ready follows", ob_ready, 1);
    chk("R4 tag passes", tl_tag, 7);
    tick();
    send(2'b01, 4'd2); chk("R4 first slot", tl_slot, 0); tick();
    send(2'b01, 4'd3); chk("R4 second slot", tl_slot, 1); tick();
    ob_valid = 1'b0; cpl_valid = 1'b1; cpl_slot = 2'd0; tick();
    cpl_valid = 1'b0;
    send(2'b11, 4'd4); chk("R11 slot reused", tl_slot, 0);
    chk("R11 no local rsp when up", rsp_valid, 0);
    tick(); ob_valid = 1'b0;
  endtask

  task automatic t_cleanup();
    mode_rc = 1'b0;
    link_up = 1'b0; send(2'b00, 4'd9);
    chk("R6 refused in event cycle", ob_ready, 0);
    tick(); ob_valid = 1'b0;
    chk("R6 cleaning set", cleaning, 1);
    chk("R5 ldd set", ldd, 1);
    chk("R7 ep link-drop clear", nsticky_clr, 1);
    chk("R6 no rsp yet", rsp_valid, 0);
    tick();
    chk("R6 first err rsp", {rsp_valid, rsp_status, 26'd0, rsp_tag}, {2'b11, 26'd0, 4'd4});
    chk("R7 clear one cycle", nsticky_clr, 0);
    chk("R6 still cleaning", cleaning, 1);
    tick();
    chk("R6 second err rsp", {rsp_valid, rsp_status, 26'd0, rsp_tag}, {2'b11, 26'd0, 4'd3});
    chk("R6 cleaning done", cleaning, 0);
    tick();
    chk("R6 no more rsp", rsp_valid, 0);
  endtask

  task automatic t_ldd();
    ldd_clr = 1'b1; tick(); ldd_clr = 1'b0;
    chk("R5 w1c clears", ldd, 0);
    link_up = 1'b1; tick();
    link_up = 1'b0; ldd_clr = 1'b1; tick(); ldd_clr = 1'b0;
    chk("R5 set wins", ldd, 1);
    tick(); tick();
    mode_rc = 1'b1; link_up = 1'b1; tick();
    link_up = 1'b0; tick();
    chk("R7 rc link-drop no clear", nsticky_clr, 0);
    chk("R6 rc link-drop cleans", cleaning, 1);
    tick(); tick();
  endtask

  task automatic t_hot_reset();
    mode_rc = 1'b1; sbr_ctl = 1'b1; #1;
    chk("R8 rc drives hot reset", hot_reset_out, 1);
    tick();
    chk("R8 rc hot reset clear", nsticky_clr, 1);
    chk("R8 rc hot reset cleans", cleaning, 1);
    sbr_ctl = 1'b0; tick(); tick();
    mode_rc = 1'b0; sbr_ctl = 1'b1; #1;
    chk("R8 ep ignores sbr", hot_reset_out, 0);
    tick();
    chk("R8 ep sbr no clear", nsticky_clr, 0);
    sbr_ctl = 1'b0; hot_reset_in = 1'b1; tick();
    chk("R7 ep detected hot reset clear", nsticky_clr, 1);
    hot_reset_in = 1'b0; tick(); tick();
  endtask

  task automatic t_inbound();
    boot_hold = 1'b1; ib_valid = 1'b1; ib_fwd_ready = 1'b0; #1;
    chk("R9 retry", ib_retry, 1);
    chk("R9 not forwarded", ib_fwd_valid, 0);
    chk("R9 consumed", ib_ready, 1);
    cfg_ready_set = 1'b1; tick(); cfg_ready_set = 1'b0; #1;
    chk("R10 forwarded after ready", {ib_retry, ib_fwd_valid, ib_ready}, 3'b010);
    hot_reset_in = 1'b1; tick(); hot_reset_in = 1'b0; tick();
    chk("R10 ready survives hot reset", cfg_ready, 1);
    rst_n = 1'b0; boot_hold = 1'b0; ib_fwd_ready = 1'b1; tick(); rst_n = 1'b1; tick();
    chk("R10 ready cleared by reset", cfg_ready, 0);
    chk("R10 no hold when boot_hold off", {ib_retry, ib_fwd_valid, ib_ready}, 3'b011);
    ib_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mode_rc = 1'b0; boot_hold = 1'b1; link_up = 1'b0;
    hot_reset_in = 1'b0; sbr_ctl = 1'b0; ldd_clr = 1'b0; cfg_ready_set = 1'b0;
    ob_valid = 1'b0; ob_class = 2'b00; ob_tag = '0; tl_ready = 1'b1;
    cpl_valid = 1'b0; cpl_slot = '0; ib_valid = 1'b0; ib_fwd_ready = 1'b0;
    tick(); tick(); rst_n = 1'b1; tick();
    t_reset();
    t_down_classes();
    t_forward();
    t_cleanup();
    t_ldd();
    t_hot_reset();
    t_inbound();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule